// File: doc/BRIEF.md
# Masked Stipple Pixel Writer

The block fills as many as 32 consecutive framebuffer pixels with one colour, chosen pixel by pixel through a 32-bit mask. Software drives it with two bus writes. The first write loads a colour register. The second write carries the mask, and its bus address gives the first destination pixel. The engine then walks the mask from its most significant bit down. It writes the latched colour to each selected pixel through its plane write ports, one pixel per clock. Clear mask bits cost no cycle.

There are always three writes per pixel available: an 8-bit pseudocolour plane, a 32-bit direct-colour plane, and a per-pixel control plane. The 8-bit plane is always written. The direct plane is written only when the deep-colour mode input is set. The control plane is also written when the command arrives through the raw window. When a command finishes, a one-cycle dirty strobe reports the first pixel and a span of 32 so that the display side can invalidate that range. The memories and the refresh logic are outside the block.

Top module: `stipple_writer`

## Requirements
- R1: An accepted 32-bit write with address bit 2 clear stores `bus_wdata[31:0]` as the colour. It starts no pixel write and raises neither busy nor the dirty strobe.
- R2: An accepted 32-bit write with address bit 2 set is a command. Its first destination pixel is `bus_addr[22:3]`, and `bus_wdata[31:0]` is the mask.
- R3: Mask bit 31 selects pixel base+0, bit 30 selects base+1, and so on down to bit 0 for base+31. Selected pixels are written in rising pixel order on consecutive cycles starting the cycle after acceptance, one cycle per set bit. Pixels with a clear bit are never written.
- R4: Each pixel write puts bits [7:0] of the latched colour on the 8-bit plane port.
- R5: With `deep_mode` set at command time, each pixel write also drives the direct plane with the colour byte-reversed: {c[7:0], c[15:8], c[23:16], c[31:24]}. With `deep_mode` clear, the direct plane is not written.
- R6: A command with `raw_sel` set and `deep_mode` set also writes that byte-reversed colour to the control plane. Without both of them set, the control plane is not written.
- R7: `rd_data` is always zero.
- R8: With `bus_wide` set, one accepted write acts as a colour write of `bus_wdata[63:32]` followed by a command with mask `bus_wdata[31:0]`. Address bit 2 is ignored, and the command uses the new colour.
- R9: `bus_ready` is low while a command runs. A write presented then is not taken and leaves the colour unchanged.
- R10: In the cycle after the last pixel write, `dirty_vld` is high for one cycle with `dirty_start` equal to the base pixel and `dirty_len` equal to 32. A command with a zero mask writes no pixel and strobes in the cycle after acceptance.
- R11: Pixel addresses wrap modulo 2^20.
- R12: After reset the block is idle and ready, no write enable or strobe is high, and the colour is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus write request |
| bus_wide | input | 1 | 64-bit write (colour and mask in one beat) |
| bus_addr | input | 23 | Byte address within the stipple window |
| bus_wdata | input | 64 | Write data; only [31:0] is used on 32-bit writes |
| raw_sel | input | 1 | Request came through the raw window |
| deep_mode | input | 1 | Deep-colour mode: direct plane present |
| bus_ready | output | 1 | Write is accepted when high |
| rd_data | output | 32 | Read data of the window, always zero |
| busy | output | 1 | Command in progress |
| px_addr | output | 20 | Pixel index of the current write |
| p8_we | output | 1 | 8-bit plane write enable |
| p8_data | output | 8 | 8-bit plane write data |
| p24_we | output | 1 | Direct plane write enable |
| p24_data | output | 32 | Direct plane write data |
| pc_we | output | 1 | Control plane write enable |
| pc_data | output | 32 | Control plane write data |
| dirty_vld | output | 1 | Completion strobe |
| dirty_start | output | 20 | First pixel of the dirty span |
| dirty_len | output | 6 | Pixel count of the dirty span |

## Verification
Masks are applied with a single top bit, a single bottom bit, both end bits, an alternating pattern, all ones and zero. Together they show that the bit-to-pixel order is not reversed, that clear bits are skipped rather than spending a cycle, and that the completion timing follows the number of set bits and not a fixed 32. The mode combinations of deep and raw show which planes receive the byte-reversed colour. A base near the top of the pixel range checks the wrap. A write presented while busy checks that the colour survives back-pressure, and a 64-bit write checks that its new colour reaches the command.

// File: rtl/stip_pkg.sv
package stip_pkg;
    localparam int PIX_W  = 20;
    localparam int MASK_W = 32;
    localparam int ADDR_W = PIX_W + 3;
    localparam int IDX_W  = $clog2(MASK_W);
    localparam int LEN_W  = IDX_W + 1;

    typedef struct packed {
        logic              busy;
        logic [MASK_W-1:0] mask;
        logic [PIX_W-1:0]  base;
        logic [31:0]       colour;
        logic              raw;
        logic              deep;
        logic              dirty;
    } stip_state_t;
endpackage

// File: rtl/stip_lead_one.sv
module stip_lead_one #(
    parameter int W   = 32,
    parameter int IW  = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic [W-1:0]  hit
);
    // idx counts from the MSB: bit W-1 gives 0
    always_comb begin
        idx = '0;
        hit = '0;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) begin
                idx = IW'(W - 1 - i);
                hit = '0;
                hit[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/stip_plane_fmt.sv
module stip_plane_fmt (
    input  logic        en,
    input  logic        deep,
    input  logic        raw,
    input  logic [31:0] colour,
    output logic        p8_we,
    output logic [7:0]  p8_data,
    output logic        p24_we,
    output logic [31:0] p24_data,
    output logic        pc_we,
    output logic [31:0] pc_data
);
    logic [31:0] swapped;

    for (genvar b = 0; b < 4; b++) begin : g_swap
        assign swapped[8*b +: 8] = colour[8*(3-b) +: 8];
    end

    assign p8_we    = en;
    assign p8_data  = colour[7:0];
    assign p24_we   = en & deep;
    assign p24_data = swapped;
    assign pc_we    = en & deep & raw;
    assign pc_data  = swapped;
endmodule

// File: rtl/stipple_writer.sv
module stipple_writer
    import stip_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_wide,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [63:0]       bus_wdata,
    input  logic              raw_sel,
    input  logic              deep_mode,
    output logic              bus_ready,
    output logic [31:0]       rd_data,
    output logic              busy,
    output logic [PIX_W-1:0]  px_addr,
    output logic              p8_we,
    output logic [7:0]        p8_data,
    output logic              p24_we,
    output logic [31:0]       p24_data,
    output logic              pc_we,
    output logic [31:0]       pc_data,
    output logic              dirty_vld,
    output logic [PIX_W-1:0]  dirty_start,
    output logic [LEN_W-1:0]  dirty_len
);
    stip_state_t st_q, st_d;

    logic [IDX_W-1:0]  lead_idx;
    logic [MASK_W-1:0] lead_hit;
    logic              accept, colour_hit, cmd_hit;

    stip_lead_one #(.W(MASK_W), .IW(IDX_W)) u_lead (
        .vec (st_q.mask),
        .idx (lead_idx),
        .hit (lead_hit)
    );

    assign bus_ready  = ~st_q.busy;
    assign accept     = bus_valid & bus_ready;
    assign colour_hit = accept & (bus_wide | ~bus_addr[2]);
    assign cmd_hit    = accept & (bus_wide |  bus_addr[2]);

    always_comb begin
        st_d       = st_q;
        st_d.dirty = 1'b0;
        if (st_q.busy) begin
            st_d.mask = st_q.mask & ~lead_hit;
            if ((st_q.mask & ~lead_hit) == '0) begin
                st_d.busy  = 1'b0;
                st_d.dirty = 1'b1;
            end
        end
        if (colour_hit) begin
            st_d.colour = bus_wide ? bus_wdata[63:32] : bus_wdata[31:0];
        end
        if (cmd_hit) begin
            st_d.base  = bus_addr[ADDR_W-1:3];
            st_d.mask  = bus_wdata[MASK_W-1:0];
            st_d.raw   = raw_sel;
            st_d.deep  = deep_mode;
            st_d.busy  = |bus_wdata[MASK_W-1:0];
            st_d.dirty = ~|bus_wdata[MASK_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    stip_plane_fmt u_fmt (
        .en       (st_q.busy),
        .deep     (st_q.deep),
        .raw      (st_q.raw),
        .colour   (st_q.colour),
        .p8_we    (p8_we),
        .p8_data  (p8_data),
        .p24_we   (p24_we),
        .p24_data (p24_data),
        .pc_we    (pc_we),
        .pc_data  (pc_data)
    );

    assign px_addr     = st_q.base + PIX_W'(lead_idx);
    assign busy        = st_q.busy;
    assign rd_data     = '0;
    assign dirty_vld   = st_q.dirty;
    assign dirty_start = st_q.base;
    assign dirty_len   = LEN_W'(MASK_W);

    // each busy cycle retires exactly one mask bit
    assert_one_bit_per_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && $countones(st_q.mask) > 1) |=>
            ($countones(st_q.mask) == $past($countones(st_q.mask)) - 1));

    assert_busy_has_work_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> (st_q.mask != '0));

    assert_colour_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && st_q.busy) |=> $stable(st_q.colour));

    assert_strobe_on_finish_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.busy) |-> dirty_vld);

    assert_direct_needs_8bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        p24_we |-> p8_we);

    assert_ctrl_needs_direct_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pc_we |-> p24_we);

    assert_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data == 32'd0);
endmodule

// File: tb/stipple_writer_bench.sv
module stipple_writer_bench;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_wide = 1'b0;
    logic [22:0] bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic        raw_sel = 1'b0;
    logic        deep_mode = 1'b0;
    logic        bus_ready, busy, p8_we, p24_we, pc_we, dirty_vld;
    logic [31:0] rd_data, p24_data, pc_data;
    logic [19:0] px_addr, dirty_start;
    logic [7:0]  p8_data;
    logic [5:0]  dirty_len;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stipple_writer u_stipple_writer (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_wide(bus_wide),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .raw_sel(raw_sel),
        .deep_mode(deep_mode), .bus_ready(bus_ready), .rd_data(rd_data),
        .busy(busy), .px_addr(px_addr), .p8_we(p8_we), .p8_data(p8_data),
        .p24_we(p24_we), .p24_data(p24_data), .pc_we(pc_we), .pc_data(pc_data),
        .dirty_vld(dirty_vld), .dirty_start(dirty_start), .dirty_len(dirty_len)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rev(input logic [31:0] c);
        return {c[7:0], c[15:8], c[23:16], c[31:24]};
    endfunction

    // one write beat; returns at the negedge after the accepting edge
    task automatic put(input logic [22:0] a, input logic [63:0] d, input bit wide,
                       input bit raw, input bit deep);
        @(negedge clk);
        bus_valid = 1'b1; bus_addr = a; bus_wdata = d; bus_wide = wide;
        raw_sel = raw; deep_mode = deep;
        @(negedge clk);
        bus_valid = 1'b0; bus_wide = 1'b0;
    endtask

    task automatic set_colour(input logic [31:0] c);
        put(23'h0, {32'h0, c}, 1'b0, 1'b0, 1'b0);
        check(!p8_we && !busy && !dirty_vld, "R1 colour write idle", {p8_we, busy, dirty_vld}, 0);
    endtask

    // observe the pixel stream of a command already accepted
    task automatic expect_run(input logic [19:0] base, input logic [31:0] mask,
                              input logic [31:0] col, input bit raw, input bit deep, input string tag);
        for (int i = 0; i < 32; i++) begin
            if (mask[31-i]) begin
                check(p8_we && busy, {tag, " R3 write enable"}, p8_we, 1);
                check(px_addr == base + 20'(i), {tag, " R3 pixel"}, px_addr, base + 20'(i));
                check(p8_data == col[7:0], {tag, " R4 8-bit data"}, p8_data, col[7:0]);
                check(p24_we == deep, {tag, " R5 direct enable"}, p24_we, deep);
                if (deep) check(p24_data == rev(col), {tag, " R5 direct data"}, p24_data, rev(col));
                check(pc_we == (deep & raw), {tag, " R6 control enable"}, pc_we, deep & raw);
                if (deep & raw) check(pc_data == rev(col), {tag, " R6 control data"}, pc_data, rev(col));
                check(!dirty_vld, {tag, " R10 no early strobe"}, dirty_vld, 0);
                @(negedge clk);
            end
        end
        check(dirty_vld && !busy && !p8_we, {tag, " R10 strobe"}, {dirty_vld, busy, p8_we}, 3'b100);
        check(dirty_start == base, {tag, " R10 start"}, dirty_start, base);
        check(dirty_len == 6'd32, {tag, " R10 length"}, dirty_len, 32);
        @(negedge clk);
        check(!dirty_vld, {tag, " R10 single cycle"}, dirty_vld, 0);
    endtask

    task automatic stipple(input logic [19:0] base, input logic [31:0] mask, input logic [31:0] col,
                           input bit raw, input bit deep, input string tag);
        put({base, 3'b100}, {32'h0, mask}, 1'b0, raw, deep);
        expect_run(base, mask, col, raw, deep, tag);
    endtask

    task automatic t_reset;
        check(!busy && bus_ready, "R12 idle after reset", {busy, bus_ready}, 2'b01);
        check(!p8_we && !p24_we && !pc_we && !dirty_vld, "R12 outputs low",
              {p8_we, p24_we, pc_we, dirty_vld}, 0);
        check(rd_data == 0, "R7 read zero", rd_data, 0);
        stipple(20'h00010, 32'h8000_0000, 32'h0, 1'b0, 1'b1, "R12 zero colour");
    endtask

    task automatic t_patterns;
        set_colour(32'h1122_3344);
        stipple(20'h00100, 32'h8000_0001, 32'h1122_3344, 1'b0, 1'b0, "R2 ends");
        stipple(20'h00200, 32'h0000_0001, 32'h1122_3344, 1'b0, 1'b0, "R3 bottom bit");
        stipple(20'h00300, 32'hAAAA_5555, 32'h1122_3344, 1'b0, 1'b0, "R3 alternate");
        stipple(20'h00400, 32'hFFFF_FFFF, 32'h1122_3344, 1'b0, 1'b0, "R3 full");
    endtask

    task automatic t_modes;
        set_colour(32'hA1B2_C3D4);
        stipple(20'h01000, 32'h0F00_0000, 32'hA1B2_C3D4, 1'b0, 1'b1, "R5 deep");
        stipple(20'h02000, 32'h00F0_0000, 32'hA1B2_C3D4, 1'b1, 1'b1, "R6 raw deep");
        stipple(20'h03000, 32'h0000_F000, 32'hA1B2_C3D4, 1'b1, 1'b0, "R6 raw shallow");
    endtask

    task automatic t_zero_and_wrap;
        put({20'h04000, 3'b100}, 64'h0, 1'b0, 1'b0, 1'b0);
        check(dirty_vld && !p8_we && !busy, "R10 zero mask strobe", {dirty_vld, p8_we, busy}, 3'b100);
        check(dirty_start == 20'h04000, "R10 zero mask start", dirty_start, 20'h04000);
        @(negedge clk);
        stipple(20'hFFFFF, 32'hC000_0000, 32'hA1B2_C3D4, 1'b0, 1'b0, "R11 wrap");
    endtask

    task automatic t_wide;
        put({20'h00050, 3'b100}, {32'h5566_7788, 32'h9000_0000}, 1'b1, 1'b0, 1'b1);
        expect_run(20'h00050, 32'h9000_0000, 32'h5566_7788, 1'b0, 1'b1, "R8 wide");
    endtask

    task automatic t_backpressure;
        set_colour(32'h0000_00EE);
        put({20'h05000, 3'b100}, {32'h0, 32'hC000_0000}, 1'b0, 1'b0, 1'b0);
        check(!bus_ready, "R9 ready low while busy", bus_ready, 0);
        bus_valid = 1'b1; bus_addr = 23'h0; bus_wdata = {32'h0, 32'h0000_0077};
        check(p8_data == 8'hEE && px_addr == 20'h05000, "R9 first write", {p8_data, px_addr}, {8'hEE, 20'h05000});
        @(negedge clk);
        bus_valid = 1'b0;
        check(p8_we && p8_data == 8'hEE, "R9 second write colour", p8_data, 8'hEE);
        @(negedge clk);
        check(dirty_vld, "R10 strobe after back-pressure", dirty_vld, 1);
        stipple(20'h06000, 32'h8000_0000, 32'h0000_00EE, 1'b0, 1'b0, "R9 colour kept");
        check(rd_data == 0, "R7 read zero later", rd_data, 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_patterns();
        t_modes();
        t_zero_and_wrap();
        t_wide();
        t_backpressure();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule